// File: doc/BRIEF.md
# Vector Element Load/Store Lane Aligner

This block moves one scalar element at a time between a 128-bit vector register file and a 32-bit memory port. A command names a vector register and carries two 32-bit address operands, a flag that zeroes the first operand, an element size and a direction. The element's memory address is the sum of the two operands, aligned down to the element size. The low four bits of that address also pick the byte position inside the vector register where the element sits.

On a load, the block fetches the memory word and extracts the element from it. It then writes only the bytes of the addressed element into the destination register, using per-byte write enables. The other bytes of the register are left untouched. On a store, the block reads the register when it accepts the command and extracts the element from the same byte position. It then drives the element onto the memory data bus at its offset within the word, with byte enables to match. The block handles one command at a time.

Top module: `vlm_lane_mover`

## Requirements
- R1: The effective address is `cmd_base + cmd_index` (modulo 2^32). When `cmd_base_zero` is 1, zero replaces `cmd_base`.
- R2: Before use, the address is aligned down to the element size: bit 0 is cleared for halfwords, and bits 1:0 are cleared for words. `mem_addr` carries this aligned byte address for the whole memory request.
- R3: `cmd_size` encodes 0 = byte (1 byte), 1 = halfword (2 bytes), 2 = word (4 bytes), and 3 is treated as a word.
- R4: A load writes the element into the vector register starting at byte position p = aligned address bits 3:0, where byte p is bits 8p+7:8p. `vrf_wbe` has exactly the element's bytes set (bits p .. p+size-1), so every other byte of the register keeps its value.
- R5: The loaded element is taken from `mem_rdata` starting at byte q = aligned address bits 1:0, with byte q at bits 8q+7:8q.
- R6: A store reads register `cmd_vreg` through `vrf_rd_addr`/`vrf_rd_data` in the cycle the command is accepted. It takes the element at byte position p, places it on `mem_wdata` starting at byte q, and sets `mem_be` bits q .. q+size-1 with `mem_we` = 1.
- R7: `mem_req` stays high, with `mem_addr` and `mem_be` unchanged, until a cycle with `mem_ack` high. `mem_be` shows the addressed bytes for loads too, with `mem_we` = 0. For a load, `vrf_we` is high for exactly one cycle: the cycle after the one in which `mem_ack` was sampled.
- R8: A command is accepted when `cmd_valid` is high while `busy` is low. `busy` and `mem_req` rise in the next cycle. `busy` falls in the cycle after the ack for a store and one cycle later for a load. Commands presented while `busy` is high are ignored.
- R9: After reset, `busy`, `mem_req` and `vrf_we` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_store | input | 1 | 1 = store, 0 = load |
| cmd_size | input | 2 | Element size code |
| cmd_base_zero | input | 1 | Use zero in place of the base operand |
| cmd_base | input | 32 | Base address operand |
| cmd_index | input | 32 | Index address operand |
| cmd_vreg | input | 5 | Vector register number |
| busy | output | 1 | Command in flight |
| vrf_rd_addr | output | 5 | Register file read address (store source) |
| vrf_rd_data | input | 128 | Register file read data |
| vrf_we | output | 1 | Register file write strobe |
| vrf_waddr | output | 5 | Register file write address |
| vrf_wdata | output | 128 | Register file write data |
| vrf_wbe | output | 16 | Per-byte write enables |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write |
| mem_addr | output | 32 | Aligned byte address |
| mem_be | output | 4 | Memory byte enables |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory acknowledge |
| mem_rdata | input | 32 | Memory read data, valid with ack |

## Verification
The memory request appears one cycle after the command is accepted. It is sampled mid-cycle on the first low clock phase after acceptance, and the bench then holds off the ack for a chosen number of cycles. A store's data and enables are compared at that first request sample. A load's register write is expected in the single cycle after the ack was sampled, so the monitor compares it at the falling edge of that cycle. The bench checks `busy` mid-cycle at each step of the sequence: just after acceptance, just after the ack, and one cycle later for loads. It also checks that a command held during the busy window does not start a second request.

// File: rtl/vlm_pkg.sv
package vlm_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_WIDE = 2'd3
   } vlm_size_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_MEM  = 2'd1,
      ST_WB   = 2'd2
   } vlm_state_e;

   // number of bytes covered by a size code (code 3 behaves as a word)
   function automatic logic [2:0] size_bytes(input logic [1:0] sz);
      case (sz)
         SZ_BYTE: return 3'd1;
         SZ_HALF: return 3'd2;
         default: return 3'd4;
      endcase
   endfunction

endpackage

// File: rtl/vlm_addr_gen.sv
module vlm_addr_gen
   import vlm_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int LANE_W = 4
) (
   input  logic [ADDR_W-1:0] base_i,
   input  logic [ADDR_W-1:0] index_i,
   input  logic              base_zero_i,
   input  logic [1:0]        size_i,
   output logic [ADDR_W-1:0] ea_o,
   output logic [LANE_W-1:0] lane_o,
   output logic [1:0]        wofs_o,
   output logic [3:0]        be_o
);

   if (LANE_W < 2 || ADDR_W < LANE_W) begin : g_bad_cfg
      $error("vlm_addr_gen: LANE_W must be >= 2 and <= ADDR_W");
   end

   logic [ADDR_W-1:0] base_term;
   logic [ADDR_W-1:0] ea_raw;
   logic [ADDR_W-1:0] align_mask;
   logic [2:0]        nbytes;

   always_comb begin
      base_term  = base_zero_i ? '0 : base_i;
      ea_raw     = base_term + index_i;
      align_mask = '1;
      if (size_i == SZ_HALF)      align_mask[0]   = 1'b0;
      else if (size_i != SZ_BYTE) align_mask[1:0] = 2'b00;
      ea_o   = ea_raw & align_mask;
      nbytes = size_bytes(size_i);
   end

   assign lane_o = ea_o[LANE_W-1:0];
   assign wofs_o = ea_o[1:0];

   for (genvar b = 0; b < 4; b++) begin : g_be
      assign be_o[b] = (3'(b) >= {1'b0, wofs_o}) && (3'(b) < ({1'b0, wofs_o} + nbytes));
   end

endmodule

// File: rtl/vlm_lane_mux.sv
module vlm_lane_mux
   import vlm_pkg::*;
#(
   parameter int VLEN   = 128,
   parameter int DATA_W = 32,
   localparam int LANES  = VLEN / 8,
   localparam int LANE_W = $clog2(LANES),
   localparam int SH_W   = LANE_W + 3
) (
   // extraction side (store): vector lane -> positioned memory word
   input  logic [LANE_W-1:0] x_lane_i,
   input  logic [1:0]        x_wofs_i,
   input  logic [1:0]        x_size_i,
   input  logic [VLEN-1:0]   x_vec_i,
   output logic [DATA_W-1:0] x_wdata_o,
   // insertion side (load): memory word -> vector lane
   input  logic [LANE_W-1:0] i_lane_i,
   input  logic [1:0]        i_wofs_i,
   input  logic [1:0]        i_size_i,
   input  logic [DATA_W-1:0] i_rdata_i,
   output logic [VLEN-1:0]   i_vec_o,
   output logic [LANES-1:0]  i_wbe_o
);

   if (DATA_W != 32) begin : g_bad_width
      $error("vlm_lane_mux: DATA_W must be 32");
   end
   if (VLEN % DATA_W != 0) begin : g_bad_vlen
      $error("vlm_lane_mux: VLEN must be a multiple of DATA_W");
   end

   function automatic logic [DATA_W-1:0] elem_mask(input logic [1:0] sz);
      case (sz)
         SZ_BYTE: return DATA_W'(8'hFF);
         SZ_HALF: return DATA_W'(16'hFFFF);
         default: return '1;
      endcase
   endfunction

   logic [VLEN-1:0]   x_shift;
   logic [DATA_W-1:0] x_elem;
   logic [DATA_W-1:0] i_elem;
   logic [2:0]        i_n;

   always_comb begin
      x_shift   = x_vec_i >> {x_lane_i, 3'b000};
      x_elem    = x_shift[DATA_W-1:0] & elem_mask(x_size_i);
      x_wdata_o = x_elem << {x_wofs_i, 3'b000};

      i_elem    = (i_rdata_i >> {i_wofs_i, 3'b000}) & elem_mask(i_size_i);
      i_vec_o   = VLEN'(i_elem) << {i_lane_i, 3'b000};
      i_n       = size_bytes(i_size_i);
   end

   for (genvar p = 0; p < LANES; p++) begin : g_wbe
      assign i_wbe_o[p] = (SH_W'(p) >= SH_W'(i_lane_i)) &&
                          (SH_W'(p) <  SH_W'(i_lane_i) + SH_W'(i_n));
   end

endmodule

// File: rtl/vlm_ctrl.sv
module vlm_ctrl
   import vlm_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic cmd_valid,
   input  logic cmd_store,
   input  logic mem_ack,
   output logic busy,
   output logic mem_req,
   output logic mem_we,
   output logic accept,
   output logic take,
   output logic wb
);

   vlm_state_e state_q, state_d;
   logic       store_q;

   assign accept  = cmd_valid && (state_q == ST_IDLE);
   assign take    = (state_q == ST_MEM) && mem_ack;
   assign wb      = (state_q == ST_WB);
   assign busy    = (state_q != ST_IDLE);
   assign mem_req = (state_q == ST_MEM);
   assign mem_we  = mem_req && store_q;

   always_comb begin
      state_d = state_q;
      case (state_q)
         ST_IDLE: if (accept) state_d = ST_MEM;
         ST_MEM:  if (mem_ack) state_d = store_q ? ST_IDLE : ST_WB;
         ST_WB:   state_d = ST_IDLE;
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         store_q <= 1'b0;
      end else begin
         state_q <= state_d;
         if (accept) store_q <= cmd_store;
      end
   end

   p_req_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> mem_req);
   p_load_wb_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_ack && !mem_we) |=> (wb && busy));
   p_wb_one_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wb |=> !wb);
   p_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> (busy && mem_req));
   p_store_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && mem_ack) |=> !busy);
   p_kind_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> $stable(mem_we));

endmodule

// File: rtl/vlm_lane_mover.sv
module vlm_lane_mover
   import vlm_pkg::*;
#(
   parameter int VLEN   = 128,
   parameter int NREG   = 32,
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   localparam int LANES  = VLEN / 8,
   localparam int LANE_W = $clog2(LANES),
   localparam int REG_W  = $clog2(NREG)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic              cmd_store,
   input  logic [1:0]        cmd_size,
   input  logic              cmd_base_zero,
   input  logic [ADDR_W-1:0] cmd_base,
   input  logic [ADDR_W-1:0] cmd_index,
   input  logic [REG_W-1:0]  cmd_vreg,
   output logic              busy,
   output logic [REG_W-1:0]  vrf_rd_addr,
   input  logic [VLEN-1:0]   vrf_rd_data,
   output logic              vrf_we,
   output logic [REG_W-1:0]  vrf_waddr,
   output logic [VLEN-1:0]   vrf_wdata,
   output logic [LANES-1:0]  vrf_wbe,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [3:0]        mem_be,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic              mem_ack,
   input  logic [DATA_W-1:0] mem_rdata
);

   if (NREG < 2 || (1 << REG_W) != NREG) begin : g_bad_nreg
      $error("vlm_lane_mover: NREG must be a power of two");
   end
   if (LANES < 4) begin : g_bad_vlen
      $error("vlm_lane_mover: VLEN must hold at least one word");
   end

   logic accept, take, wb;

   logic [ADDR_W-1:0] ea_c;
   logic [LANE_W-1:0] lane_c;
   logic [1:0]        wofs_c;
   logic [3:0]        be_c;
   logic [DATA_W-1:0] swd_c;
   logic [VLEN-1:0]   ld_vec;
   logic [LANES-1:0]  ld_wbe;

   logic [ADDR_W-1:0] ea_q;
   logic [LANE_W-1:0] lane_q;
   logic [1:0]        wofs_q;
   logic [1:0]        size_q;
   logic [REG_W-1:0]  vreg_q;
   logic [3:0]        be_q;
   logic [DATA_W-1:0] swd_q;
   logic [DATA_W-1:0] rd_q;

   vlm_ctrl u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_valid (cmd_valid),
      .cmd_store (cmd_store),
      .mem_ack   (mem_ack),
      .busy      (busy),
      .mem_req   (mem_req),
      .mem_we    (mem_we),
      .accept    (accept),
      .take      (take),
      .wb        (wb)
   );

   vlm_addr_gen #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_agen (
      .base_i      (cmd_base),
      .index_i     (cmd_index),
      .base_zero_i (cmd_base_zero),
      .size_i      (cmd_size),
      .ea_o        (ea_c),
      .lane_o      (lane_c),
      .wofs_o      (wofs_c),
      .be_o        (be_c)
   );

   vlm_lane_mux #(.VLEN(VLEN), .DATA_W(DATA_W)) u_mux (
      .x_lane_i  (lane_c),
      .x_wofs_i  (wofs_c),
      .x_size_i  (cmd_size),
      .x_vec_i   (vrf_rd_data),
      .x_wdata_o (swd_c),
      .i_lane_i  (lane_q),
      .i_wofs_i  (wofs_q),
      .i_size_i  (size_q),
      .i_rdata_i (rd_q),
      .i_vec_o   (ld_vec),
      .i_wbe_o   (ld_wbe)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ea_q   <= '0;
         lane_q <= '0;
         wofs_q <= '0;
         size_q <= '0;
         vreg_q <= '0;
         be_q   <= '0;
         swd_q  <= '0;
         rd_q   <= '0;
      end else begin
         if (accept) begin
            ea_q   <= ea_c;
            lane_q <= lane_c;
            wofs_q <= wofs_c;
            size_q <= cmd_size;
            vreg_q <= cmd_vreg;
            be_q   <= be_c;
            swd_q  <= swd_c;
         end
         if (take) rd_q <= mem_rdata;
      end
   end

   assign vrf_rd_addr = cmd_vreg;
   assign mem_addr    = ea_q;
   assign mem_be      = be_q;
   assign mem_wdata   = swd_q;
   assign vrf_we      = wb;
   assign vrf_waddr   = vreg_q;
   assign vrf_wdata   = ld_vec;
   assign vrf_wbe     = wb ? ld_wbe : '0;

   p_addr_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> ($stable(mem_addr) && $stable(mem_be)));
   p_wbe_size_r4: assert property (@(posedge clk) disable iff (!rst_n)
      vrf_we |-> ($countones(vrf_wbe) == 1 || $countones(vrf_wbe) == 2 ||
                  $countones(vrf_wbe) == 4));
   p_we_after_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
      vrf_we |-> $past(mem_ack));
   p_store_be_r6: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> (mem_be != 4'b0000));
   p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!mem_req && !vrf_we));

endmodule

// File: tb/vlm_lane_mover_tb_top.sv
module vlm_lane_mover_tb_top;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         cmd_valid = 1'b0;
   logic         cmd_store = 1'b0;
   logic [1:0]   cmd_size = '0;
   logic         cmd_base_zero = 1'b0;
   logic [31:0]  cmd_base = '0;
   logic [31:0]  cmd_index = '0;
   logic [4:0]   cmd_vreg = '0;
   logic         busy;
   logic [4:0]   vrf_rd_addr;
   logic [127:0] vrf_rd_data = '0;
   logic         vrf_we;
   logic [4:0]   vrf_waddr;
   logic [127:0] vrf_wdata;
   logic [15:0]  vrf_wbe;
   logic         mem_req;
   logic         mem_we;
   logic [31:0]  mem_addr;
   logic [3:0]   mem_be;
   logic [31:0]  mem_wdata;
   logic         mem_ack = 1'b0;
   logic [31:0]  mem_rdata = '0;

   int total = 0;
   int bad = 0;

   always #5 clk = ~clk;

   vlm_lane_mover dut_i (
      .clk(clk), .rst_n(rst_n),
      .cmd_valid(cmd_valid), .cmd_store(cmd_store), .cmd_size(cmd_size),
      .cmd_base_zero(cmd_base_zero), .cmd_base(cmd_base), .cmd_index(cmd_index),
      .cmd_vreg(cmd_vreg), .busy(busy),
      .vrf_rd_addr(vrf_rd_addr), .vrf_rd_data(vrf_rd_data),
      .vrf_we(vrf_we), .vrf_waddr(vrf_waddr), .vrf_wdata(vrf_wdata), .vrf_wbe(vrf_wbe),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
      .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
   );

   typedef struct {
      bit           st;
      logic [31:0]  addr;
      logic [3:0]   be;
      logic [31:0]  wdata;
      logic [4:0]   vreg;
      logic [15:0]  wbe;
      logic [127:0] vdata;
   } exp_t;

   exp_t sb[$];
   bit   mem_seen = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [127:0] act, input logic [127:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [127:0] mkvec(input logic [7:0] seed);
      logic [127:0] v;
      for (int k = 0; k < 16; k++) v[8*k +: 8] = seed + 8'(k * 8'h1D);
      return v;
   endfunction

   // monitor: compares memory requests and register writes against the queue
   always @(negedge clk) begin
      if (rst_n) begin
         if (!mem_req) mem_seen = 0;
         if (mem_req && !mem_seen) begin
            mem_seen = 1;
            if (sb.size() == 0) chk(0, "R8", "unexpected mem request", 128'(mem_addr), 0);
            else begin
               chk(mem_addr == sb[0].addr, "R1/R2", "mem_addr", 128'(mem_addr), 128'(sb[0].addr));
               chk(mem_be == sb[0].be, "R7", "mem_be", 128'(mem_be), 128'(sb[0].be));
               chk(mem_we == sb[0].st, "R6", "mem_we", 128'(mem_we), 128'(sb[0].st));
               if (sb[0].st) begin
                  chk(mem_wdata == sb[0].wdata, "R6", "mem_wdata", 128'(mem_wdata), 128'(sb[0].wdata));
                  void'(sb.pop_front());
               end
            end
         end
         if (vrf_we) begin
            if (sb.size() == 0 || sb[0].st) chk(0, "R7", "unexpected vrf_we", 128'(vrf_wbe), 0);
            else begin
               logic [127:0] m;
               for (int p = 0; p < 16; p++) m[8*p +: 8] = {8{vrf_wbe[p]}};
               chk(vrf_waddr == sb[0].vreg, "R4", "vrf_waddr", 128'(vrf_waddr), 128'(sb[0].vreg));
               chk(vrf_wbe == sb[0].wbe, "R4", "vrf_wbe", 128'(vrf_wbe), 128'(sb[0].wbe));
               chk((vrf_wdata & m) == sb[0].vdata, "R4/R5", "vrf_wdata", vrf_wdata & m, sb[0].vdata);
               void'(sb.pop_front());
            end
         end
      end
   end

   // driver: computes the expected result from the requirements and runs one command
   task automatic do_op(input bit st, input logic [1:0] sz, input bit bz,
                        input logic [31:0] b, input logic [31:0] ix, input logic [4:0] vr,
                        input logic [127:0] vec, input logic [31:0] rd,
                        input int dly, input bit jam);
      exp_t e;
      logic [31:0] ea;
      int n, lane, wo;
      n  = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
      ea = (bz ? 32'd0 : b) + ix;
      ea = ea & ~32'(n - 1);
      lane = int'(ea[3:0]);
      wo   = int'(ea[1:0]);
      e.st    = st;
      e.addr  = ea;
      e.be    = 4'(((1 << n) - 1) << wo);
      e.vreg  = vr;
      e.wbe   = 16'(((1 << n) - 1) << lane);
      e.wdata = '0;
      e.vdata = '0;
      if (st) begin
         logic [31:0] el;
         el = 32'(vec >> (8 * lane));
         if (n < 4) el = el & ((32'd1 << (8 * n)) - 1);
         e.wdata = el << (8 * wo);
      end else begin
         logic [31:0] el;
         el = rd >> (8 * wo);
         if (n < 4) el = el & ((32'd1 << (8 * n)) - 1);
         e.vdata = 128'(el) << (8 * lane);
      end
      sb.push_back(e);

      @(negedge clk); #1;
      cmd_valid = 1; cmd_store = st; cmd_size = sz; cmd_base_zero = bz;
      cmd_base = b; cmd_index = ix; cmd_vreg = vr; vrf_rd_data = vec;
      @(negedge clk); #1;
      chk(busy && mem_req, "R8", "busy/req after accept", 128'({busy, mem_req}), 128'(2'b11));
      vrf_rd_data = ~vec;
      cmd_valid = jam;
      if (jam) begin
         cmd_store = ~st; cmd_base = b ^ 32'h5A5A_0F0F; cmd_vreg = vr ^ 5'h1F;
      end
      for (int i = 0; i < dly; i++) begin
         @(negedge clk); #1;
         chk(mem_req, "R7", "req held before ack", 128'(mem_req), 128'(1));
      end
      cmd_valid = 0;
      mem_ack = 1; mem_rdata = rd;
      @(negedge clk); #1;
      mem_ack = 0; mem_rdata = ~rd;
      if (st) chk(!busy, "R8", "store busy after ack", 128'(busy), 0);
      else begin
         chk(busy && !mem_req, "R8", "load busy in write cycle", 128'({busy, mem_req}), 128'(2'b10));
         @(negedge clk); #1;
         chk(!busy && !vrf_we, "R7", "load done one cycle after write", 128'({busy, vrf_we}), 0);
      end
      @(negedge clk); #1;
      chk(!busy && !mem_req, "R8", "idle after command", 128'({busy, mem_req}), 0);
   endtask

   initial begin
      #(200000 * 10);
      bad++;
      total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (2) @(negedge clk);
      #1;
      chk(!busy && !mem_req && !vrf_we, "R9", "reset outputs", 128'({busy, mem_req, vrf_we}), 0);
      rst_n = 1;
      @(negedge clk); #1;
      chk(!busy && !mem_req, "R9", "idle after reset release", 128'({busy, mem_req}), 0);

      // R1 R4 R5: byte load, lane 3
      do_op(0, 2'd0, 0, 32'h0000_1000, 32'h3, 5'd4, mkvec(8'h10), 32'hAABB_CCDD, 2, 0);
      // R1: base forced to zero
      do_op(0, 2'd0, 1, 32'hDEAD_BEEF, 32'h2A, 5'd9, mkvec(8'h20), 32'h1122_3344, 0, 0);
      // R2: odd halfword address aligned down
      do_op(0, 2'd1, 0, 32'h0000_0100, 32'h7, 5'd1, mkvec(8'h30), 32'h5566_7788, 1, 0);
      // R2 R3: word load, low bits cleared
      do_op(0, 2'd2, 0, 32'h0000_0200, 32'h7, 5'd2, mkvec(8'h40), 32'hCAFE_F00D, 3, 0);
      // R3: size code 3 behaves as word
      do_op(0, 2'd3, 0, 32'h0000_0300, 32'hE, 5'd31, mkvec(8'h50), 32'h0BAD_1DEA, 0, 0);
      // R6: byte store from lane 15
      do_op(1, 2'd0, 0, 32'h0000_0010, 32'hF, 5'd7, mkvec(8'h60), 32'h0, 1, 0);
      // R6: halfword store from lane 6
      do_op(1, 2'd1, 1, 32'hFFFF_FFFF, 32'h0000_4006, 5'd3, mkvec(8'h70), 32'h0, 0, 0);
      // R6 R2: word store from lane 8
      do_op(1, 2'd2, 0, 32'hFFFF_FFF0, 32'h1B, 5'd12, mkvec(8'h80), 32'h0, 2, 0);
      // R8: commands held while busy are ignored
      do_op(1, 2'd0, 0, 32'h0000_0500, 32'h5, 5'd5, mkvec(8'h90), 32'h0, 4, 1);
      do_op(0, 2'd1, 0, 32'h0000_0600, 32'hC, 5'd6, mkvec(8'hA0), 32'h8899_AABB, 3, 1);
      // sweep of sizes, lanes and directions
      for (int k = 0; k < 24; k++) begin
         do_op(k[0], 2'(k % 3), k[2], 32'h1000 * k, 32'(k * 5 + 1), 5'(k),
               mkvec(8'(k * 7)), 32'h1357_9BDF ^ 32'(k * 32'h0101_0101), k % 3, 0);
      end

      chk(sb.size() == 0, "R7", "scoreboard drained", 128'(sb.size()), 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule